// File: doc/BRIEF.md
# Shared-Bus 8-bit Stepped Processor

This block is a small 8-bit processor built around one internal byte bus. Each instruction takes seven clock cycles, called steps. Steps 1 to 3 fetch the opcode. Steps 4 to 6 carry out the instruction. Step 7 does nothing and returns the sequencer to step 1. In every step a control unit enables at most one source onto the bus and strobes the registers that capture the bus value. The registers are:

- a program counter;
- a memory address register;
- an instruction register;
- an ALU input latch;
- an ALU result accumulator;
- a four-bit flag register;
- four general registers, R0 to R3.

A 256-byte RAM sits inside the block. A preload port writes the RAM while the core is held in reset. A read-only peek port lets the environment inspect RAM contents.

The instruction that loads a literal is two bytes long. Its execute steps make a second memory read and a second increment of the program counter, so the next fetch starts after the literal byte. There is no halt. Once a program ends, the core keeps fetching whatever follows it, so the environment runs a known number of instructions and then inspects memory.

Top module: `bus_cpu8`

## Requirements
- R1: The synchronous reset `rst` clears the program counter, all registers and the flags, and places the sequencer at step 1. RAM contents are kept, and the preload port can write RAM while `rst` is high.
- R2: While out of reset, `stepOut` follows the sequence 1,2,...,7,1,..., so one instruction completes every seven clocks.
- R3: The fetch adds one to the program counter through the ALU increment path. After any single-byte instruction, `pcOut` is the opcode address plus one.
- R4: An opcode of the form 0010_xxBB is a two-byte literal load. It copies the byte that follows the opcode into register B (bits 1-0) and leaves `pcOut` two past the opcode address.
- R5: An opcode of the form 0001_AABB writes register B into RAM at the address held in register A (bits 3-2).
- R6: An opcode of the form 0000_AABB loads register B with RAM at the address held in register A.
- R7: An opcode of the form 1000_AABB writes (A + B) mod 256 into register B. The carry flag takes bit 8 of the sum.
- R8: Bits 6-4 of an opcode with bit 7 set select the ALU operation: 001 shift A right, 010 shift A left, 011 invert A, 100 AND, 101 OR, 110 XOR. Each writes its result to register B. Code 111 compares A with B and writes no register.
- R9: `flagsOut` is {carry, A greater than B, A equal to B, result zero}, with carry in bit 3. For shifts, carry is the bit shifted out; for operations other than add and shift it is 0. Only operations with bit 7 set update the flags.
- R10: Opcodes 0011_xxxx through 0111_xxxx change no register, no RAM byte and no flag, and advance the program counter by one.
- R11: No step enables more than one bus driver.
- R12: The eight-byte program 0x20,5,0x21,3,0x81,0x20,14,0x11 run from address 0 for five instructions leaves 8 in RAM[14] and flags 0100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| preloadEn | input | 1 | RAM write strobe from the environment |
| preloadAddr | input | 8 | Preload address |
| preloadData | input | 8 | Preload byte |
| peekAddr | input | 8 | RAM inspection address |
| peekData | output | 8 | RAM byte at `peekAddr`, combinational |
| stepOut | output | 3 | Current step, 1 to 7 |
| pcOut | output | 8 | Program counter |
| flagsOut | output | 4 | {carry, greater, equal, zero} |

## Verification
Two things overlap in the literal load. In its step 4, the ALU increments the program counter while the bus carries the program counter into the address register. In step 6, the program counter is rewritten a second time in the same instruction. A wrong skip would make the core execute the literal as an opcode.

The bench sweeps all 256 literal values in register R3 and then stores that register. This includes literals that decode as stores, loads and ALU operations, so any misalignment shows up as a wrong RAM byte or a wrong final program counter. ALU operations are swept across eight operand corners for every operation code, and result and flags are compared with arithmetic done in the bench.

// File: rtl/bus_cpu8_pkg.sv
package bus_cpu8_pkg;
  localparam int WORD_W = 8;
  localparam int NREG   = 4;
  localparam int SEL_W  = $clog2(NREG);
  localparam int STEP_W = 3;
  localparam int FLAG_W = 4;

  localparam logic [3:0] OPC_LOAD  = 4'h0;
  localparam logic [3:0] OPC_STORE = 4'h1;
  localparam logic [3:0] OPC_LIT   = 4'h2;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0, ALU_SHR = 3'd1, ALU_SHL = 3'd2, ALU_NOT = 3'd3,
    ALU_AND = 3'd4, ALU_OR  = 3'd5, ALU_XOR = 3'd6, ALU_CMP = 3'd7
  } aluOp_e;

  typedef struct packed {
    logic             drvPc;
    logic             drvRam;
    logic             drvAcc;
    logic             drvReg;
    logic [SEL_W-1:0] drvSel;
    logic             setMar;
    logic             setIr;
    logic             setPc;
    logic             setAcc;
    logic             setTmp;
    logic             setReg;
    logic [SEL_W-1:0] setSel;
    logic             setRam;
    logic             setFlags;
    logic             aluInc;
    aluOp_e           aluOp;
  } ctlStrobes_t;
endpackage

// File: rtl/cpu_ram.sv
module cpu_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          cpuWe,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] cpuWdata,
  output logic [DW-1:0] cpuRdata,
  input  logic          preloadEn,
  input  logic [AW-1:0] preloadAddr,
  input  logic [DW-1:0] preloadData,
  input  logic [AW-1:0] peekAddr,
  output logic [DW-1:0] peekData
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          wrEn;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;

  // environment preload wins over a core write in the same cycle
  always_comb begin
    wrEn   = preloadEn | cpuWe;
    wrAddr = preloadEn ? preloadAddr : cpuAddr;
    wrData = preloadEn ? preloadData : cpuWdata;
  end

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  assign cpuRdata = mem[cpuAddr];
  assign peekData = mem[peekAddr];
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import bus_cpu8_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         inc,
  input  aluOp_e       op,
  output logic [W-1:0] result,
  output logic         carry,
  output logic         aGreater,
  output logic         aEqual,
  output logic         isZero
);
  logic [W:0] sum;

  always_comb begin
    sum   = {1'b0, a} + {1'b0, b};
    carry = 1'b0;
    if (inc) begin
      result = a + {{(W-1){1'b0}}, 1'b1};
    end else begin
      unique case (op)
        ALU_ADD: begin result = sum[W-1:0]; carry = sum[W]; end
        ALU_SHR: begin result = {1'b0, a[W-1:1]}; carry = a[0]; end
        ALU_SHL: begin result = {a[W-2:0], 1'b0}; carry = a[W-1]; end
        ALU_NOT: result = ~a;
        ALU_AND: result = a & b;
        ALU_OR:  result = a | b;
        ALU_XOR: result = a ^ b;
        default: result = a ^ b;
      endcase
    end
    aGreater = a > b;
    aEqual   = a == b;
    isZero   = result == '0;
  end
endmodule

// File: rtl/cpu_control.sv
module cpu_control
  import bus_cpu8_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      ir,
  output logic [STEP_W-1:0] step,
  output ctlStrobes_t       ctl
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(7);

  logic             isAlu, isCmp;
  logic [SEL_W-1:0] aSel, bSel;

  always_ff @(posedge clk) begin
    if (rst)                    step <= STEP_W'(1);
    else if (step == LAST_STEP) step <= STEP_W'(1);
    else                        step <= step + STEP_W'(1);
  end

  always_comb begin
    isAlu = ir[W-1];
    isCmp = ir[6:4] == 3'b111;
    aSel  = ir[2*SEL_W-1:SEL_W];
    bSel  = ir[SEL_W-1:0];
    ctl   = '0;
    unique case (step)
      STEP_W'(1): begin
        ctl.drvPc = 1'b1; ctl.setMar = 1'b1; ctl.aluInc = 1'b1; ctl.setAcc = 1'b1;
      end
      STEP_W'(2): begin ctl.drvRam = 1'b1; ctl.setIr = 1'b1; end
      STEP_W'(3): begin ctl.drvAcc = 1'b1; ctl.setPc = 1'b1; end
      STEP_W'(4): begin
        if (isAlu) begin
          ctl.drvReg = 1'b1; ctl.drvSel = bSel; ctl.setTmp = 1'b1;
        end else if (ir[7:4] == OPC_LOAD || ir[7:4] == OPC_STORE) begin
          ctl.drvReg = 1'b1; ctl.drvSel = aSel; ctl.setMar = 1'b1;
        end else if (ir[7:4] == OPC_LIT) begin
          ctl.drvPc = 1'b1; ctl.setMar = 1'b1; ctl.aluInc = 1'b1; ctl.setAcc = 1'b1;
        end
      end
      STEP_W'(5): begin
        if (isAlu) begin
          ctl.drvReg = 1'b1; ctl.drvSel = aSel; ctl.setAcc = 1'b1;
          ctl.setFlags = 1'b1; ctl.aluOp = aluOp_e'(ir[6:4]);
        end else if (ir[7:4] == OPC_LOAD || ir[7:4] == OPC_LIT) begin
          ctl.drvRam = 1'b1; ctl.setReg = 1'b1; ctl.setSel = bSel;
        end else if (ir[7:4] == OPC_STORE) begin
          ctl.drvReg = 1'b1; ctl.drvSel = bSel; ctl.setRam = 1'b1;
        end
      end
      STEP_W'(6): begin
        if (isAlu && !isCmp) begin
          ctl.drvAcc = 1'b1; ctl.setReg = 1'b1; ctl.setSel = bSel;
        end else if (ir[7:4] == OPC_LIT) begin
          ctl.drvAcc = 1'b1; ctl.setPc = 1'b1;
        end
      end
      default: ;
    endcase
  end

  a_r2_step_walk: assert property (@(posedge clk) disable iff (rst)
    (step != LAST_STEP) |=> (step == $past(step) + STEP_W'(1)));
  a_r2_step_wrap: assert property (@(posedge clk) disable iff (rst)
    (step == LAST_STEP) |=> (step == STEP_W'(1)));
endmodule

// File: rtl/cpu_datapath.sv
module cpu_datapath
  import bus_cpu8_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       ctl,
  input  logic              preloadEn,
  input  logic [W-1:0]      preloadAddr,
  input  logic [W-1:0]      preloadData,
  input  logic [W-1:0]      peekAddr,
  output logic [W-1:0]      peekData,
  output logic [W-1:0]      irOut,
  output logic [W-1:0]      pcOut,
  output logic [FLAG_W-1:0] flagsOut
);
  logic [W-1:0]      pcReg, marReg, irReg, tmpReg, accReg;
  logic [FLAG_W-1:0] flagReg;
  logic [W-1:0]      gpr [NREG];
  logic [W-1:0]      bus, ramRd, aluRes;
  logic              aluC, aluGt, aluEq, aluZ;

  always_comb begin
    bus = '0;
    if      (ctl.drvPc)  bus = pcReg;
    else if (ctl.drvRam) bus = ramRd;
    else if (ctl.drvAcc) bus = accReg;
    else if (ctl.drvReg) bus = gpr[ctl.drvSel];
  end

  cpu_alu #(.W(W)) u_alu (
    .a(bus), .b(tmpReg), .inc(ctl.aluInc), .op(ctl.aluOp),
    .result(aluRes), .carry(aluC), .aGreater(aluGt), .aEqual(aluEq), .isZero(aluZ)
  );

  cpu_ram #(.AW(W), .DW(W)) u_ram (
    .clk(clk), .cpuWe(ctl.setRam), .cpuAddr(marReg), .cpuWdata(bus), .cpuRdata(ramRd),
    .preloadEn(preloadEn), .preloadAddr(preloadAddr), .preloadData(preloadData),
    .peekAddr(peekAddr), .peekData(peekData)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pcReg <= '0; marReg <= '0; irReg <= '0; tmpReg <= '0; accReg <= '0; flagReg <= '0;
    end else begin
      if (ctl.setPc)    pcReg   <= bus;
      if (ctl.setMar)   marReg  <= bus;
      if (ctl.setIr)    irReg   <= bus;
      if (ctl.setTmp)   tmpReg  <= bus;
      if (ctl.setAcc)   accReg  <= aluRes;
      if (ctl.setFlags) flagReg <= {aluC, aluGt, aluEq, aluZ};
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_gpr
    always_ff @(posedge clk) begin
      if (rst)                                        gpr[g] <= '0;
      else if (ctl.setReg && ctl.setSel == SEL_W'(g)) gpr[g] <= bus;
    end
  end

  assign irOut    = irReg;
  assign pcOut    = pcReg;
  assign flagsOut = flagReg;

  a_r11_single_driver: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.drvPc, ctl.drvRam, ctl.drvAcc, ctl.drvReg}));
endmodule

// File: rtl/bus_cpu8.sv
module bus_cpu8
  import bus_cpu8_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        preloadEn,
  input  logic [7:0]  preloadAddr,
  input  logic [7:0]  preloadData,
  input  logic [7:0]  peekAddr,
  output logic [7:0]  peekData,
  output logic [2:0]  stepOut,
  output logic [7:0]  pcOut,
  output logic [3:0]  flagsOut
);
  ctlStrobes_t       ctl;
  logic [WORD_W-1:0] irVal;
  logic [STEP_W-1:0] step;

  cpu_control #(.W(WORD_W)) u_control (
    .clk(clk), .rst(rst), .ir(irVal), .step(step), .ctl(ctl)
  );

  cpu_datapath #(.W(WORD_W)) u_datapath (
    .clk(clk), .rst(rst), .ctl(ctl),
    .preloadEn(preloadEn), .preloadAddr(preloadAddr), .preloadData(preloadData),
    .peekAddr(peekAddr), .peekData(peekData),
    .irOut(irVal), .pcOut(pcOut), .flagsOut(flagsOut)
  );

  assign stepOut = step;

  a_r3_fetch_advance: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd3) |=> (pcOut == $past(pcOut) + 8'd1));
  a_r4_literal_skip: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd6 && irVal[7:4] == OPC_LIT) |=> (pcOut == $past(pcOut) + 8'd1));
  a_r10_exec_pc_hold: assert property (@(posedge clk) disable iff (rst)
    (step >= 3'd4 && irVal[7:4] != OPC_LIT) |=> $stable(pcOut));
endmodule

// File: tb/bus_cpu8_bench.sv
`timescale 1ns/1ps
module bus_cpu8_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       preloadEn = 1'b0;
  logic [7:0] preloadAddr = '0, preloadData = '0, peekAddr = '0;
  logic [7:0] peekData, pcOut;
  logic [2:0] stepOut;
  logic [3:0] flagsOut;

  int vectors = 0;
  int fails   = 0;
  logic [7:0] img [16];
  int imgLen = 0;

  always #2.5 clk = ~clk;

  bus_cpu8 u_bus_cpu8 (
    .clk(clk), .rst(rst), .preloadEn(preloadEn), .preloadAddr(preloadAddr),
    .preloadData(preloadData), .peekAddr(peekAddr), .peekData(peekData),
    .stepOut(stepOut), .pcOut(pcOut), .flagsOut(flagsOut)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    preloadEn = 1'b1; preloadAddr = a; preloadData = d;
    @(negedge clk);
    preloadEn = 1'b0;
  endtask

  function automatic logic [7:0] peek(input logic [7:0] a);
    peekAddr = a;
    return 8'hxx;
  endfunction

  task automatic readMem(input logic [7:0] a, output logic [7:0] d);
    peekAddr = a;
    #1;
    d = peekData;
  endtask

  task automatic loadImage();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < imgLen; i++) poke(8'(i), img[i]);
  endtask

  task automatic runInstr(input int n);
    @(negedge clk);
    rst = 1'b0;
    repeat (7 * n) @(negedge clk);
  endtask

  function automatic logic [7:0] corner(input int i);
    case (i)
      0: return 8'h00; 1: return 8'h01; 2: return 8'h7F; 3: return 8'h80;
      4: return 8'hFE; 5: return 8'hFF; 6: return 8'h55; default: return 8'hAA;
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stim
    logic [7:0] d;
    void'(peek(8'h00));
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 step", stepOut, 1);
    check("R1 pc", pcOut, 0);
    check("R1 flags", flagsOut, 0);

    // R12 sample program, with R2 step walk and R3/R4 pc trail
    img[0]=8'h20; img[1]=8'd5; img[2]=8'h21; img[3]=8'd3;
    img[4]=8'h81; img[5]=8'h20; img[6]=8'd14; img[7]=8'h11; imgLen = 8;
    loadImage();
    poke(8'd14, 8'd0);
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 35; k++) begin
      check("R2 step sequence", stepOut, (k % 7) + 1);
      if (k == 7)  check("R4 pc after literal", pcOut, 2);
      if (k == 14) check("R4 pc after literal", pcOut, 4);
      if (k == 21) check("R3 pc after add", pcOut, 5);
      if (k == 28) check("R4 pc after literal", pcOut, 7);
      @(negedge clk);
    end
    check("R3 pc after store", pcOut, 8);
    readMem(8'd14, d);
    check("R12 result byte", d, 8);
    check("R12 flags", flagsOut, 4'b0100);

    // R4: every literal into R3, then stored at 0x60
    for (int v = 0; v < 256; v++) begin
      img[0]=8'h23; img[1]=8'(v); img[2]=8'h20; img[3]=8'h60; img[4]=8'h13; imgLen = 5;
      loadImage();
      poke(8'h60, ~8'(v));
      runInstr(3);
      readMem(8'h60, d);
      check("R4 literal into R3 / R5 store", d, v);
      check("R4 pc skip", pcOut, 5);
    end

    // R6: load through register address
    for (int i = 0; i < 8; i++) begin
      img[0]=8'h20; img[1]=8'h40; img[2]=8'h03; img[3]=8'h21; img[4]=8'h41; img[5]=8'h17;
      imgLen = 6;
      loadImage();
      poke(8'h40, corner(i)); poke(8'h41, ~corner(i));
      runInstr(4);
      readMem(8'h41, d);
      check("R6 load", d, corner(i));
    end

    // R10: opcodes 3x..7x do nothing
    for (int h = 3; h < 8; h++) begin
      for (int l = 0; l < 16; l += 5) begin
        img[0]=8'h20; img[1]=8'h50; img[2]=8'h21; img[3]=8'h77;
        img[4]=8'((h << 4) | l); img[5]=8'h11; imgLen = 6;
        loadImage();
        poke(8'h50, 8'h00);
        runInstr(3);
        check("R10 no-op pc", pcOut, 5);
        check("R10 no-op flags", flagsOut, 0);
        runInstr(1);
        readMem(8'h50, d);
        check("R10 no-op keeps regs", d, 8'h77);
      end
    end

    // R7/R8/R9: ALU sweep over every op and operand corners
    for (int op = 0; op < 8; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          logic [7:0] x, y, r, stored;
          logic c;
          x = corner(i); y = corner(j); c = 1'b0;
          case (op)
            0: {c, r} = {1'b0, x} + {1'b0, y};
            1: begin r = x >> 1; c = x[0]; end
            2: begin r = x << 1; c = x[7]; end
            3: r = ~x;
            4: r = x & y;
            5: r = x | y;
            default: r = x ^ y;
          endcase
          stored = (op == 7) ? y : r;
          img[0]=8'h20; img[1]=x; img[2]=8'h21; img[3]=y;
          img[4]=8'(8'h81 | (op << 4)); img[5]=8'h22; img[6]=8'hF0; img[7]=8'h19; imgLen = 8;
          loadImage();
          poke(8'hF0, ~stored);
          runInstr(5);
          readMem(8'hF0, d);
          if (op == 0) check("R7 add result", d, stored);
          else         check("R8 alu result", d, stored);
          check("R9 flags", flagsOut, {c, x > y, x == y, r == 8'h00});
        end
      end
    end

    // R1: reset clears flags left by the last run
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 flags after reset", flagsOut, 0);
    check("R1 pc after reset", pcOut, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule